// File: doc/BRIEF.md
# Accumulator Register-Operation Unit

This block carries out the register-only instructions of a single-accumulator processor. The sequencer raises a strobe during the execute step and presents the instruction word along with the current accumulator and the one-bit link register that sits beside it. When the word belongs to the register-operation class, the block works out the new accumulator and link values. It also reports whether the program counter must advance one extra word to skip the next instruction, and whether the machine must halt.

The word is in the class when bits 15..12 equal `4'b0111`. Bit 15 is the addressing-mode bit, which must be 0, and bits 14..12 hold the opcode, which must be 7. The low twelve bits are a one-hot selection field. A word may set several selection bits. The selected operations then run in a fixed order, and each one sees the result of the one before. Results are registered, so they appear one clock after the strobe.

A small state machine has two states, `ST_RUN` and `ST_HALT`. The transition `RUN_TO_HALT` is taken on an accepted word with the halt bit set. `HALT_HOLD` keeps the machine in `ST_HALT` until reset. `RUN_STAY` covers every other cycle in `ST_RUN`.

Top module: `acc_regop_unit`

## Requirements
- R1: A word is accepted only when `exec_en` is 1, `instr_word[15:12]` is `4'b0111`, and the block is not halted. In any other cycle `ac_next` and `e_next` hold their values and `skip_req` is 0 in the following cycle.
- R2: Accumulator operations: bit 11 clears the accumulator, bit 9 inverts every bit of it, and bit 5 adds one to it, modulo 2^16.
- R3: Link operations: bit 10 clears the link and bit 8 inverts it.
- R4: Bit 7 rotates right through the link. The new accumulator is {old link, old AC[15:1]} and the new link is the old AC[0].
- R5: Bit 6 rotates left through the link. The new accumulator is {old AC[14:0], old link} and the new link is the old AC[15].
- R6: Sign tests: bit 4 requests a skip when AC[15] is 0, so zero counts as positive, and bit 3 requests a skip when AC[15] is 1.
- R7: Zero tests: bit 2 requests a skip when the accumulator is all zero, and bit 1 requests a skip when the link is 0.
- R8: When several selection bits are set, the operations apply in this order: clear AC, clear link, invert AC, invert link, rotate right, rotate left, increment. The skip tests then look at the resulting values, and the skip request is the OR of the selected tests. A word with no selection bits (`16'h7000`) returns the inputs unchanged and requests no skip.
- R9: Bit 0 on an accepted word moves the machine to `ST_HALT` after the other selected operations have applied. While halted, `halted` is 1, and both the outputs and the halt state stay as they are until reset.
- R10: Timing: the results of an accepted word appear on `ac_next`, `e_next` and `skip_req` on the first clock edge after the strobe. `skip_req` lasts exactly one cycle.
- R11: While `rst_n` is low, `ac_next` is 0, `e_next` is 0, `skip_req` is 0 and `halted` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Execute-step strobe from the sequencer |
| instr_word | input | 16 | Instruction word |
| ac_in | input | 16 | Current accumulator |
| e_in | input | 1 | Current link bit |
| ac_next | output | 16 | Updated accumulator |
| e_next | output | 1 | Updated link bit |
| skip_req | output | 1 | One-cycle request for an extra program-counter increment |
| halted | output | 1 | Machine halted; stays set until reset |

## Verification
The assertions check on every cycle that halting is sticky and freezes the outputs. They also check that words outside the class, or cycles without the strobe, leave the outputs unchanged with no skip, and that the clear, invert and both rotate operations give the right single-operation results one cycle after the strobe. The bench scenarios cover the rest. These are the skip decisions at the sign and zero boundaries, the increment wrap, and the ordering of combined words, where a skip test must see values an earlier operation already changed. They also cover a halt combined with other operations, and recovery through reset.

// File: rtl/regop_pkg.sv
package regop_pkg;
    localparam int SEL_W = 12;

    localparam int B_CLR_AC  = 11;
    localparam int B_CLR_E   = 10;
    localparam int B_INV_AC  = 9;
    localparam int B_INV_E   = 8;
    localparam int B_ROT_R   = 7;
    localparam int B_ROT_L   = 6;
    localparam int B_INC_AC  = 5;
    localparam int B_SK_POS  = 4;
    localparam int B_SK_NEG  = 3;
    localparam int B_SK_ZAC  = 2;
    localparam int B_SK_ZE   = 1;
    localparam int B_HALT    = 0;

    localparam logic [3:0] CLASS_CODE = 4'b0111;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_e;
endpackage

// File: rtl/regop_datapath.sv
module regop_datapath
    import regop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              e_in,
    output logic [DATA_W-1:0] ac_out,
    output logic              e_out
);
    logic [DATA_W-1:0] a;
    logic              l;

    always_comb begin
        a = ac_in;
        l = e_in;
        if (sel[B_CLR_AC]) a = '0;
        if (sel[B_CLR_E])  l = 1'b0;
        if (sel[B_INV_AC]) a = ~a;
        if (sel[B_INV_E])  l = ~l;
        if (sel[B_ROT_R])  {a, l} = {l, a};
        if (sel[B_ROT_L])  {l, a} = {a, l};
        if (sel[B_INC_AC]) a = a + {{(DATA_W-1){1'b0}}, 1'b1};
        ac_out = a;
        e_out  = l;
    end
endmodule

// File: rtl/regop_skip.sv
module regop_skip
    import regop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] ac_val,
    input  logic              e_val,
    output logic              skip
);
    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg  = ac_val[DATA_W-1];
        is_zero = (ac_val == '0);
        skip    = (sel[B_SK_POS] & ~is_neg)
                | (sel[B_SK_NEG] &  is_neg)
                | (sel[B_SK_ZAC] &  is_zero)
                | (sel[B_SK_ZE]  & ~e_val);
    end
endmodule

// File: rtl/regop_fsm.sv
module regop_fsm
    import regop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_hit,
    input  logic halt_bit,
    output logic accept,
    output logic halted
);
    run_state_e state_q;
    run_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (word_hit && halt_bit) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        accept = 1'b0;
        halted = 1'b0;
        unique case (state_q)
            ST_RUN:  accept = word_hit;
            ST_HALT: halted = 1'b1;
            default: accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_regop_unit.sv
module acc_regop_unit
    import regop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              e_in,
    output logic [DATA_W-1:0] ac_next,
    output logic              e_next,
    output logic              skip_req,
    output logic              halted
);
    localparam int CLS_LSB = WORD_W - 4;

    logic [SEL_W-1:0]  sel;
    logic              word_hit;
    logic              accept;
    logic [DATA_W-1:0] ac_calc;
    logic              e_calc;
    logic              skip_calc;

    assign sel      = instr_word[SEL_W-1:0];
    assign word_hit = exec_en && (instr_word[WORD_W-1:CLS_LSB] == CLASS_CODE);

    regop_datapath #(.DATA_W(DATA_W)) u_dp (
        .sel    (sel),
        .ac_in  (ac_in),
        .e_in   (e_in),
        .ac_out (ac_calc),
        .e_out  (e_calc)
    );

    regop_skip #(.DATA_W(DATA_W)) u_skip (
        .sel    (sel),
        .ac_val (ac_calc),
        .e_val  (e_calc),
        .skip   (skip_calc)
    );

    regop_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_hit (word_hit),
        .halt_bit (sel[B_HALT]),
        .accept   (accept),
        .halted   (halted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_next  <= '0;
            e_next   <= 1'b0;
            skip_req <= 1'b0;
        end else begin
            skip_req <= accept && skip_calc;
            if (accept) begin
                ac_next <= ac_calc;
                e_next  <= e_calc;
            end
        end
    end
endmodule

// File: rtl/regop_checker.sv
module regop_checker #(
    parameter int DATA_W = 16,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_en,
    input logic [WORD_W-1:0] instr_word,
    input logic [DATA_W-1:0] ac_in,
    input logic              e_in,
    input logic [DATA_W-1:0] ac_next,
    input logic              e_next,
    input logic              skip_req,
    input logic              halted
);
    logic live;
    assign live = exec_en && !halted;

    // R9: halt is sticky
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9: halted machine freezes its outputs
    p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(ac_next) && $stable(e_next) && !skip_req));

    // R1: no strobe, no change
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> ($stable(ac_next) && $stable(e_next) && !skip_req));

    // R1: words of other classes are ignored
    p_class_filter_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && instr_word[WORD_W-1:WORD_W-4] != 4'b0111)
        |=> ($stable(ac_next) && $stable(e_next) && !skip_req));

    // R2: clear accumulator alone
    p_clear_ac_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && instr_word == 16'h7800)
        |=> (ac_next == '0 && e_next == $past(e_in)));

    // R2: invert accumulator alone
    p_invert_ac_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && instr_word == 16'h7200)
        |=> (ac_next == ~$past(ac_in)));

    // R3: invert link alone
    p_invert_e_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && instr_word == 16'h7100)
        |=> (e_next == !$past(e_in) && ac_next == $past(ac_in)));

    // R4: rotate right through link
    p_rot_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && instr_word == 16'h7080)
        |=> ({ac_next, e_next} == {$past(e_in), $past(ac_in)}));

    // R5: rotate left through link
    p_rot_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && instr_word == 16'h7040)
        |=> ({e_next, ac_next} == {$past(ac_in), $past(e_in)}));

    // R10: skip is a single-cycle pulse
    p_skip_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && !exec_en) |=> !skip_req);
endmodule

bind acc_regop_unit regop_checker #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_en    (exec_en),
    .instr_word (instr_word),
    .ac_in      (ac_in),
    .e_in       (e_in),
    .ac_next    (ac_next),
    .e_next     (e_next),
    .skip_req   (skip_req),
    .halted     (halted)
);

// File: tb/tb_acc_regop_unit.sv
module tb_acc_regop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [15:0] instr_word = '0;
    logic [15:0] ac_in = '0;
    logic        e_in = 1'b0;
    logic [15:0] ac_next;
    logic        e_next;
    logic        skip_req;
    logic        halted;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    acc_regop_unit dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr_word(instr_word),
        .ac_in(ac_in), .e_in(e_in), .ac_next(ac_next), .e_next(e_next),
        .skip_req(skip_req), .halted(halted)
    );

    // {req, instr, ac, e, exp_ac, exp_e, exp_skip}
    localparam int NV = 21;
    localparam logic [54:0] VEC [0:NV-1] = '{
        {4'd2,  16'h7800, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0}, // R2 clear
        {4'd3,  16'h7400, 16'h1234, 1'b1, 16'h1234, 1'b0, 1'b0}, // R3 clear link
        {4'd2,  16'h7200, 16'h00FF, 1'b0, 16'hFF00, 1'b0, 1'b0}, // R2 invert
        {4'd3,  16'h7100, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0}, // R3 invert link
        {4'd4,  16'h7080, 16'h8001, 1'b0, 16'h4000, 1'b1, 1'b0}, // R4
        {4'd5,  16'h7040, 16'h8001, 1'b0, 16'h0002, 1'b1, 1'b0}, // R5
        {4'd2,  16'h7020, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 1'b0}, // R2 wrap
        {4'd6,  16'h7010, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1}, // R6 zero positive
        {4'd6,  16'h7010, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b0}, // R6
        {4'd6,  16'h7008, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b1}, // R6 negative
        {4'd7,  16'h7004, 16'h0001, 1'b0, 16'h0001, 1'b0, 1'b0}, // R7
        {4'd7,  16'h7004, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1}, // R7
        {4'd7,  16'h7002, 16'h0005, 1'b0, 16'h0005, 1'b0, 1'b1}, // R7
        {4'd7,  16'h7002, 16'h0005, 1'b1, 16'h0005, 1'b1, 1'b0}, // R7
        {4'd8,  16'h7A00, 16'h1234, 1'b0, 16'hFFFF, 1'b0, 1'b0}, // R8 clear then invert
        {4'd8,  16'h7220, 16'h0005, 1'b1, 16'hFFFB, 1'b1, 1'b0}, // R8 invert then inc
        {4'd8,  16'h7804, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b1}, // R8 test after clear
        {4'd8,  16'h7540, 16'h4000, 1'b0, 16'h8001, 1'b0, 1'b0}, // R8 link ops then rotate
        {4'd8,  16'h7088, 16'h0001, 1'b1, 16'h8000, 1'b1, 1'b1}, // R8 rotate then sign
        {4'd8,  16'h7000, 16'hABCD, 1'b1, 16'hABCD, 1'b1, 1'b0}, // R8 empty word
        {4'd8,  16'h7042, 16'h8000, 1'b1, 16'h0001, 1'b1, 1'b0}  // R8 rotate then link test
    };

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic en, input logic [15:0] w, input logic [15:0] a, input logic e);
        @(negedge clk);
        exec_en = en; instr_word = w; ac_in = a; e_in = e;
        @(negedge clk);
        exec_en = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset", {ac_next, e_next, skip_req}, 18'h0);
        checks++; if (halted !== 1'b0) begin failures++; $display("FAIL R11 halted actual=%b expected=0", halted); end
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            strobe(1'b1, VEC[i][50:35], VEC[i][34:19], VEC[i][18]);
            checks++;
            if ({ac_next, e_next, skip_req} !== VEC[i][17:0]) begin
                failures++;
                $display("FAIL R%0d row %0d actual=%h expected=%h", VEC[i][54:51], i,
                         {ac_next, e_next, skip_req}, VEC[i][17:0]);
            end
        end

        // R10 skip pulse: set skip, then idle one cycle
        strobe(1'b1, 16'h7004, 16'h0000, 1'b0);
        check("R10 skip set", {ac_next, e_next, skip_req}, {16'h0000, 1'b0, 1'b1});
        @(negedge clk);
        check("R10 skip drops", {ac_next, e_next, skip_req}, {16'h0000, 1'b0, 1'b0});

        // R1 other class, mode bit set, and no strobe
        strobe(1'b1, 16'h7020, 16'h00AA, 1'b1);
        check("R1 setup", {ac_next, e_next, skip_req}, {16'h00AB, 1'b1, 1'b0});
        strobe(1'b1, 16'h3800, 16'h5555, 1'b0);
        check("R1 other opcode", {ac_next, e_next, skip_req}, {16'h00AB, 1'b1, 1'b0});
        strobe(1'b1, 16'hF804, 16'h0000, 1'b0);
        check("R1 mode bit", {ac_next, e_next, skip_req}, {16'h00AB, 1'b1, 1'b0});
        strobe(1'b0, 16'h7804, 16'h0000, 1'b0);
        check("R1 no strobe", {ac_next, e_next, skip_req}, {16'h00AB, 1'b1, 1'b0});

        // R9 halt combined with increment
        strobe(1'b1, 16'h7021, 16'h7FFF, 1'b0);
        check("R9 halt+inc", {ac_next, e_next, skip_req}, {16'h8000, 1'b0, 1'b0});
        checks++; if (halted !== 1'b1) begin failures++; $display("FAIL R9 halted actual=%b expected=1", halted); end
        strobe(1'b1, 16'h7804, 16'h1111, 1'b1);
        check("R9 frozen", {ac_next, e_next, skip_req}, {16'h8000, 1'b0, 1'b0});
        checks++; if (halted !== 1'b1) begin failures++; $display("FAIL R9 sticky actual=%b expected=1", halted); end

        // R11 reset clears halt, then R2 works again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset again", {ac_next, e_next, skip_req}, 18'h0);
        checks++; if (halted !== 1'b0) begin failures++; $display("FAIL R11 unhalt actual=%b expected=0", halted); end
        rst_n = 1'b1;
        strobe(1'b1, 16'h7200, 16'h0F0F, 1'b0);
        check("R2 after reset", {ac_next, e_next, skip_req}, {16'hF0F0, 1'b0, 1'b0});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule